// File: doc/BRIEF.md
# Pointer range and alignment checker

This unit decides, for each request, whether a 64-bit target pointer may be used. The pointer is allowed when it lies inside a region that starts at a base address and holds a given number of equal slots. It must also sit on a slot boundary, and it must, if asked, land on a slot that a small inline mask marks as legal. The slot size is a power of two chosen by a 4-bit log2 field. The slot count is a 20-bit field.

The unit takes the offset from the base and rotates it right by the alignment. Any offset bit below the slot size then lands in the high bits of the index. One unsigned compare of that index against the slot count rejects out-of-range and misaligned pointers together. A borrow from the subtraction rejects pointers below the base, even when the region wraps past the top of the address space. The same index selects a bit of the validity mask. A cheaper equality mode accepts only the base itself.

A failing check either traps or asks for a branch to a handler address, depending on whether the supplied handler address is zero. Requests arrive on a valid/ready handshake, one per cycle. The result is registered and is held until the consumer takes it.

Top module: `ptr_guard`

## Requirements
- R1: While rst is high, and on the cycle after it, out_valid is 0. With out_valid at 0, in_ready is 1.
- R2: in_ready equals (not out_valid) or out_ready. A request taken at a clock edge (in_valid and in_ready both high) shows its result with out_valid high immediately after that edge. While out_valid is high and out_ready is low, every output holds and no new request is taken. When out_ready is high and no request arrives, out_valid falls after the edge.
- R3: Range mode (in_mode code 1) passes only when base <= ptr < base + (count << align). Both sides are taken as exact unsigned values with no wrap at 2^64. The low `align` bits of (ptr - base) must also all be zero.
- R4: In range mode and in vector mode, a slot count of zero makes every pointer fail.
- R5: Vector mode (in_mode code 2) passes only when the range mode would pass and bit number ((ptr - base) >> align) of in_vec is 1. Bit 0 is the least significant bit. An index of 64 or more fails, unless R6 applies.
- R6: In vector mode, an in_vec of all ones skips the bit test, so the result equals the range-mode result for any slot index.
- R7: Equality mode (in_mode code 0) passes exactly when in_ptr equals in_base, whatever the values of in_align, in_count and in_vec.
- R8: Mode code 3 is reserved, and every request made with it fails.
- R9: When a check fails, an in_fail_tgt of zero gives out_trap with out_addr 0. A non-zero in_fail_tgt gives out_redirect, with out_addr equal to in_fail_tgt. A passing check gives out_addr 0.
- R10: While out_valid is high, exactly one of out_pass, out_trap and out_redirect is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A request is present |
| in_ready | output | 1 | The unit takes a request at this edge |
| in_mode | input | 2 | 0 equality, 1 range, 2 range plus vector, 3 reserved |
| in_ptr | input | 64 | Pointer under test |
| in_base | input | 64 | First address of the region |
| in_align | input | 4 | log2 of the slot size in bytes |
| in_count | input | 20 | Number of slots in the region |
| in_vec | input | 64 | Per-slot validity mask, bit i for slot i |
| in_fail_tgt | input | 64 | Handler address on failure, 0 means trap |
| out_valid | output | 1 | A result is present |
| out_ready | input | 1 | The consumer takes the result |
| out_pass | output | 1 | The pointer is allowed |
| out_trap | output | 1 | The check failed and must trap |
| out_redirect | output | 1 | The check failed and must branch to out_addr |
| out_addr | output | 64 | Handler address when out_redirect is high, else 0 |

## Verification
Each decision comes out on the registered result one edge after the request is taken, so any error in the index or compare logic shows on that same result. A misaligned low bit that is lost in the rotate, or a borrow that is not seen, turns a trap or redirect into a false pass. The pointers one byte below the base, exactly at the end bound, and at every misalignment force that outcome on the first bad request. A fault in the handshake register shows as a result that changes while stalled, or a request dropped or taken twice, and this appears within two cycles of a stall.

// File: rtl/ptr_guard_pkg.sv
package ptr_guard_pkg;
  typedef enum logic [1:0] {
    MODE_EQUAL  = 2'd0,
    MODE_RANGE  = 2'd1,
    MODE_BITVEC = 2'd2,
    MODE_RSVD   = 2'd3
  } chk_mode_e;
endpackage

// File: rtl/ptr_guard_index.sv
// Offset, rotate and bound compare. The index lands high on any misalignment.
module ptr_guard_index #(
  parameter int PTR_W   = 64,
  parameter int ALIGN_W = 4,
  parameter int COUNT_W = 20
) (
  input  logic [PTR_W-1:0]   ptr,
  input  logic [PTR_W-1:0]   base,
  input  logic [ALIGN_W-1:0] align,
  input  logic [COUNT_W-1:0] count,
  output logic [PTR_W-1:0]   index,
  output logic               in_range
);
  localparam int PAD_W = PTR_W - COUNT_W;

  logic [PTR_W:0]   diff;
  logic             borrow;
  logic [PTR_W-1:0] stg [ALIGN_W+1];

  assign diff   = {1'b0, ptr} - {1'b0, base};
  assign borrow = diff[PTR_W];
  assign stg[0] = diff[PTR_W-1:0];

  // Barrel rotate right, one stage per bit of the alignment field.
  for (genvar k = 0; k < ALIGN_W; k++) begin : g_rot
    localparam int SH = 1 << k;
    assign stg[k+1] = align[k] ? {stg[k][SH-1:0], stg[k][PTR_W-1:SH]} : stg[k];
  end

  assign index    = stg[ALIGN_W];
  assign in_range = !borrow && (index < {{PAD_W{1'b0}}, count});
endmodule

// File: rtl/ptr_guard_slot.sv
// Inline validity mask test on the slot index.
module ptr_guard_slot #(
  parameter int PTR_W = 64,
  parameter int VEC_W = 64
) (
  input  logic [PTR_W-1:0] index,
  input  logic [VEC_W-1:0] vec,
  output logic             slot_ok
);
  localparam int IDX_W = $clog2(VEC_W);

  logic all_set;
  logic idx_fits;

  assign all_set  = &vec;
  assign idx_fits = index < PTR_W'(VEC_W);
  assign slot_ok  = all_set || (idx_fits && vec[index[IDX_W-1:0]]);
endmodule

// File: rtl/ptr_guard_route.sv
// Maps the verdict and handler address onto the three result flags.
module ptr_guard_route #(
  parameter int PTR_W = 64
) (
  input  logic             ok,
  input  logic [PTR_W-1:0] fail_tgt,
  output logic             pass,
  output logic             trap,
  output logic             redirect,
  output logic [PTR_W-1:0] addr
);
  logic tgt_zero;

  assign tgt_zero = (fail_tgt == '0);
  assign pass     = ok;
  assign trap     = !ok && tgt_zero;
  assign redirect = !ok && !tgt_zero;
  assign addr     = redirect ? fail_tgt : '0;
endmodule

// File: rtl/ptr_guard.sv
module ptr_guard
  import ptr_guard_pkg::*;
#(
  parameter int PTR_W   = 64,
  parameter int ALIGN_W = 4,
  parameter int COUNT_W = 20,
  parameter int VEC_W   = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [1:0]         in_mode,
  input  logic [PTR_W-1:0]   in_ptr,
  input  logic [PTR_W-1:0]   in_base,
  input  logic [ALIGN_W-1:0] in_align,
  input  logic [COUNT_W-1:0] in_count,
  input  logic [VEC_W-1:0]   in_vec,
  input  logic [PTR_W-1:0]   in_fail_tgt,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_pass,
  output logic               out_trap,
  output logic               out_redirect,
  output logic [PTR_W-1:0]   out_addr
);
  logic [PTR_W-1:0] index;
  logic             in_range;
  logic             slot_ok;
  logic             ok;
  logic             c_pass, c_trap, c_redirect;
  logic [PTR_W-1:0] c_addr;
  logic             accept;

  ptr_guard_index #(.PTR_W(PTR_W), .ALIGN_W(ALIGN_W), .COUNT_W(COUNT_W)) u_index (
    .ptr(in_ptr), .base(in_base), .align(in_align), .count(in_count),
    .index(index), .in_range(in_range)
  );

  ptr_guard_slot #(.PTR_W(PTR_W), .VEC_W(VEC_W)) u_slot (
    .index(index), .vec(in_vec), .slot_ok(slot_ok)
  );

  always_comb begin
    unique case (chk_mode_e'(in_mode))
      MODE_EQUAL:  ok = (in_ptr == in_base);
      MODE_RANGE:  ok = in_range;
      MODE_BITVEC: ok = in_range && slot_ok;
      default:     ok = 1'b0;
    endcase
  end

  ptr_guard_route #(.PTR_W(PTR_W)) u_route (
    .ok(ok), .fail_tgt(in_fail_tgt),
    .pass(c_pass), .trap(c_trap), .redirect(c_redirect), .addr(c_addr)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_pass     <= 1'b0;
      out_trap     <= 1'b0;
      out_redirect <= 1'b0;
      out_addr     <= '0;
    end else if (accept) begin
      out_valid    <= 1'b1;
      out_pass     <= c_pass;
      out_trap     <= c_trap;
      out_redirect <= c_redirect;
      out_addr     <= c_addr;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

  // Independent misalignment view, used only by the checks below.
  logic [PTR_W-1:0] a_off;
  logic [PTR_W-1:0] a_mask;
  logic             a_misaligned;
  assign a_off        = in_ptr - in_base;
  assign a_mask       = (PTR_W'(1) << in_align) - PTR_W'(1);
  assign a_misaligned = |(a_off & a_mask);

  p_reset_r1: assert property (@(posedge clk) rst |=> !out_valid);

  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pass) && $stable(out_trap)
      && $stable(out_redirect) && $stable(out_addr)));

  p_misalign_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && in_mode == MODE_RANGE && a_misaligned) |=> !out_pass);

  p_below_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && in_mode != MODE_EQUAL && in_ptr < in_base) |=> !out_pass);

  p_zero_count_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && in_mode != MODE_EQUAL && in_count == '0) |=> !out_pass);

  p_equal_r7: assert property (@(posedge clk) disable iff (rst)
    (accept && in_mode == MODE_EQUAL) |=> (out_pass == $past(in_ptr == in_base)));

  p_reserved_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && in_mode == MODE_RSVD) |=> !out_pass);

  p_addr_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_redirect) |-> (out_addr == '0));

  p_one_flag_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones({out_pass, out_trap, out_redirect}) == 1));
endmodule

// File: tb/ptr_guard_bench.sv
module ptr_guard_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_mode = '0;
  logic [63:0] in_ptr = '0, in_base = '0, in_vec = '0, in_fail_tgt = '0;
  logic [3:0]  in_align = '0;
  logic [19:0] in_count = '0;
  logic        out_valid, out_ready = 1'b1;
  logic        out_pass, out_trap, out_redirect;
  logic [63:0] out_addr;

  int total = 0;
  int fails = 0;

  always #2.5ns clk = ~clk;

  ptr_guard u_ptr_guard (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_ptr(in_ptr), .in_base(in_base), .in_align(in_align),
    .in_count(in_count), .in_vec(in_vec), .in_fail_tgt(in_fail_tgt),
    .out_valid(out_valid), .out_ready(out_ready), .out_pass(out_pass),
    .out_trap(out_trap), .out_redirect(out_redirect), .out_addr(out_addr)
  );

  // Result codes: 0 pass, 1 trap, 2 redirect.
  typedef struct packed {
    logic [1:0]  mode;
    logic [63:0] ptr;
    logic [63:0] base;
    logic [3:0]  align;
    logic [19:0] count;
    logic [63:0] vec;
    logic [63:0] fail;
    logic [1:0]  exp;
  } vec_t;

  localparam logic [63:0] B0  = 64'h1000;
  localparam logic [63:0] BT  = 64'hFFFF_FFFF_FFFF_FF00;
  localparam logic [63:0] ONE = '1;
  localparam logic [63:0] HND = 64'h4000;

  localparam vec_t TABLE [15] = '{
    '{2'd1, 64'h1000, B0, 4'd3, 20'd4, 64'h0, 64'h0, 2'd0},               // R3 first slot
    '{2'd1, 64'h1018, B0, 4'd3, 20'd4, 64'h0, 64'h0, 2'd0},               // R3 last slot
    '{2'd1, 64'h1020, B0, 4'd3, 20'd4, 64'h0, 64'h0, 2'd1},               // R3 end bound
    '{2'd1, 64'h0FF8, B0, 4'd3, 20'd4, 64'h0, 64'hDEAD0, 2'd2},           // R3 below base
    '{2'd1, 64'h1004, B0, 4'd3, 20'd4, 64'h0, 64'h0, 2'd1},               // R3 misaligned
    '{2'd2, 64'h1008, B0, 4'd3, 20'd4, 64'h5, 64'h0, 2'd1},               // R5 clear bit
    '{2'd2, 64'h1010, B0, 4'd3, 20'd4, 64'h5, 64'h0, 2'd0},               // R5 set bit
    '{2'd2, 64'h1280, B0, 4'd3, 20'd100, ONE, 64'h0, 2'd0},               // R6 index 80
    '{2'd2, 64'h1280, B0, 4'd3, 20'd100, 64'hF, HND, 2'd2},               // R5 index past mask
    '{2'd0, 64'h1000, B0, 4'd9, 20'd0, 64'h0, 64'h0, 2'd0},               // R7 equal
    '{2'd0, 64'h1008, B0, 4'd3, 20'd4, ONE, 64'h0, 2'd1},                 // R7 not equal
    '{2'd3, 64'h1000, B0, 4'd3, 20'd4, ONE, HND, 2'd2},                   // R8 reserved
    '{2'd1, 64'h1000, B0, 4'd3, 20'd0, 64'h0, 64'h0, 2'd1},               // R4 empty region
    '{2'd1, 64'hFFFF_FFFF_FFFF_FFF0, BT, 4'd4, 20'hFFFFF, 64'h0, 64'h0, 2'd0}, // R3 top of space
    '{2'd1, 64'h10, BT, 4'd4, 20'hFFFFF, 64'h0, 64'h0, 2'd1}              // R3 wrapped pointer
  };

  function automatic logic [1:0] model(input logic [1:0] mode, input logic [63:0] ptr,
      input logic [63:0] base, input logic [3:0] align, input logic [19:0] count,
      input logic [63:0] vec, input logic [63:0] fail);
    logic [79:0] lo, hi;
    logic [63:0] off, idx;
    logic        rok, ok;
    lo  = {16'b0, base};
    hi  = {16'b0, base} + ({60'b0, count} << align);
    off = ptr - base;
    idx = off >> align;
    rok = ({16'b0, ptr} >= lo) && ({16'b0, ptr} < hi) && ((off % (64'd1 << align)) == 0);
    case (mode)
      2'd0:    ok = (ptr == base);
      2'd1:    ok = rok;
      2'd2:    ok = rok && ((vec == '1) || (idx < 64 && vec[idx[5:0]]));
      default: ok = 1'b0;
    endcase
    return ok ? 2'd0 : ((fail == 0) ? 2'd1 : 2'd2);
  endfunction

  function automatic string mode_tag(input logic [1:0] mode);
    case (mode)
      2'd0:    return "R7";
      2'd1:    return "R3";
      2'd2:    return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] mode, input logic [63:0] ptr, input logic [63:0] base,
      input logic [3:0] align, input logic [19:0] count, input logic [63:0] vec,
      input logic [63:0] fail);
    @(negedge clk);
    in_mode = mode; in_ptr = ptr; in_base = base; in_align = align;
    in_count = count; in_vec = vec; in_fail_tgt = fail; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_result(input string tag, input logic [1:0] code, input logic [63:0] fail);
    logic [2:0]  flags;
    logic [63:0] eaddr;
    flags = (code == 2'd0) ? 3'b100 : (code == 2'd1) ? 3'b010 : 3'b001;
    eaddr = (code == 2'd2) ? fail : 64'h0;
    check({tag, " valid"}, 64'(out_valid), 64'd1);
    check({tag, " R10 flags"}, 64'({out_pass, out_trap, out_redirect}), 64'(flags));
    check({tag, " R9 addr"}, out_addr, eaddr);
  endtask

  initial begin
    #500us;
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 out_valid in reset", 64'(out_valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid after reset", 64'(out_valid), 64'd0);
    check("R1 in_ready idle", 64'(in_ready), 64'd1);

    for (int i = 0; i < 15; i++) begin
      drive(TABLE[i].mode, TABLE[i].ptr, TABLE[i].base, TABLE[i].align,
            TABLE[i].count, TABLE[i].vec, TABLE[i].fail);
      check_result(mode_tag(TABLE[i].mode), TABLE[i].exp, TABLE[i].fail);
      check("bench model", 64'(model(TABLE[i].mode, TABLE[i].ptr, TABLE[i].base,
            TABLE[i].align, TABLE[i].count, TABLE[i].vec, TABLE[i].fail)), 64'(TABLE[i].exp));
    end

    // R2 idle drop
    @(negedge clk);
    check("R2 valid drops when idle", 64'(out_valid), 64'd0);

    // R2 backpressure: result A (pass) must hold while request B waits.
    out_ready = 1'b0;
    drive(2'd1, 64'h1000, B0, 4'd3, 20'd4, 64'h0, 64'h0);
    check("R2 in_ready stalled", 64'(in_ready), 64'd0);
    in_mode = 2'd1; in_ptr = 64'h1020; in_base = B0; in_align = 4'd3;
    in_count = 20'd4; in_fail_tgt = 64'h0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_result("R2 held", 2'd0, 64'h0);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check_result("R2 after release", 2'd1, 64'h0);

    // R1 reset while a result is stalled
    out_ready = 1'b0;
    drive(2'd0, 64'h1000, B0, 4'd0, 20'd0, 64'h0, 64'h0);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    out_ready = 1'b1;
    check("R1 reset clears stalled result", 64'(out_valid), 64'd0);

    // Randomised boundary sweep against the bench model.
    for (int n = 0; n < 400; n++) begin
      logic [1:0]  mode;
      logic [63:0] base, ptr, vec, fail, step;
      logic [3:0]  align;
      logic [19:0] count;
      int          sel;
      align = 4'($urandom % 16);
      count = 20'($urandom % 80);
      base  = {$urandom, $urandom} & ~((64'd1 << align) - 64'd1);
      step  = 64'd1 << align;
      sel   = $urandom % 6;
      case (sel)
        0:       ptr = base - 64'(1 + $urandom % 16);
        1:       ptr = base + (64'(count) << align);
        2:       ptr = base + (64'(count) << align) - step;
        3:       ptr = base + (64'($urandom % (count + 1)) << align) + 64'($urandom % step);
        4:       ptr = base + (64'($urandom % 128) << align);
        default: ptr = {$urandom, $urandom};
      endcase
      mode = 2'($urandom % 4);
      if (mode == 2'd0 && ($urandom % 2) == 0) ptr = base;
      vec  = (($urandom % 4) == 0) ? ONE : {$urandom, $urandom};
      fail = (($urandom % 2) == 0) ? 64'h0 : {$urandom, $urandom} | 64'h1;
      drive(mode, ptr, base, align, count, vec, fail);
      check_result({mode_tag(mode), " random"}, model(mode, ptr, base, align, count, vec, fail), fail);
    end

    // R3 every misalignment at a fixed region
    for (int m = 1; m < 16; m++) begin
      drive(2'd1, 64'h2000 + 64'(m), 64'h2000, 4'd4, 20'd8, 64'h0, 64'h0);
      check_result("R3 misalign", 2'd1, 64'h0);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule